// File: doc/BRIEF.md
# Interrupt Latch and Keyed Soft-Reset Register Block

This block sits beside a two-wire bus controller and turns eight single-cycle event pulses into a software-visible interrupt scheme. Each event sets a sticky bit in a status register. An enable register selects which status bits may raise the interrupt, and one global gate bit decides whether the single interrupt line is driven at all. Software acknowledges an event by writing a 1 to its status bit.

The same register window holds a keyed reset register. Writing the one valid key value produces a single-clock soft-reset pulse for the rest of the controller. The same write also wipes the status and enable registers. A write of any other value to that register does nothing.

Access is through a plain 32-bit register port made of address, write strobe, write data and combinational read data. Writes take effect at the clock edge where the strobe is high.

Top module: `irq_rst_regs`

## Requirements
- R1: After reset, the status, enable and global-gate registers are zero, `irq_out` is low and `soft_rst_pulse` is low.
- R2: An event on `evt_in[i]` sets status bit i at that clock edge, visible at offset 0x20. The bit order is 0 arbitration lost, 1 transmit error, 2 transmit empty, 3 receive full, 4 bus idle, 5 addressed as target, 6 no longer addressed as target, 7 transmit half empty. Bits 31:8 of 0x20 read zero.
- R3: A write to 0x20 clears each status bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at 0x28 stores write-data bits 7:0 and reads back bits 31:8 as zero.
- R6: `irq_out` is high exactly when the global gate is on and at least one bit is set in both the status and enable registers. It follows register changes in the same cycle.
- R7: The global-gate register at 0x1C holds only bit 31, taken from write-data bit 31. Every other bit reads zero.
- R8: Writing exactly 0x0000000A to 0x40 raises `soft_rst_pulse` for the one cycle after that edge. The same edge clears status and enable. An event arriving in that same cycle is dropped. The global gate keeps its value.
- R9: Writing any other value to 0x40 produces no pulse and leaves all registers unchanged.
- R10: Reads of 0x40 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_in | input | 8 | Event pulses, one bit per source |
| irq_out | output | 1 | Gated interrupt request |
| soft_rst_pulse | output | 1 | One-cycle soft-reset request |

## Verification
Every register write and every event is captured at the clock edge where it is presented. Read data and `irq_out` are combinational from the registers, so they show the new state right after that same edge. `soft_rst_pulse` is registered and is high during the cycle that follows the key write. The bench therefore drives each stimulus at a falling edge. It drops the strobe and events 1 ns after the next rising edge, steers the address to the register of interest, and samples 1 ns later. This reads results in the first cycle they are due and never a cycle late.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned REG_DATA_W  = 32;
  localparam int unsigned REG_ADDR_W  = 8;
  localparam int unsigned EVT_COUNT   = 8;
  localparam int unsigned GATE_BIT    = 31;
  localparam logic [7:0]  OFS_GATE    = 8'h1C;
  localparam logic [7:0]  OFS_STATUS  = 8'h20;
  localparam logic [7:0]  OFS_ENABLE  = 8'h28;
  localparam logic [7:0]  OFS_RESET   = 8'h40;
  localparam logic [31:0] RESET_KEY   = 32'h0000_000A;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               ena_we,
  input  logic [NUM_SRC-1:0] ena_wdata,
  input  logic               soft_clr,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] pending
);
  // sticky update: clear-by-one first, then events re-set (event wins)
  function automatic logic [NUM_SRC-1:0] sticky_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] clr,
    input logic [NUM_SRC-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [NUM_SRC-1:0] masked(
    input logic [NUM_SRC-1:0] st,
    input logic [NUM_SRC-1:0] en
  );
    return st & en;
  endfunction

  logic [NUM_SRC-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (soft_clr) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= sticky_next(status, clr_eff, evt);
      if (ena_we) enable <= ena_wdata;
    end
  end

  assign pending = masked(status, enable);

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0)); // R2

  AST_SOFT_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status == '0 && enable == '0)); // R8
endmodule

// File: rtl/soft_reset_decoder.sv
module soft_reset_decoder #(
  parameter int unsigned    DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_hit,
  output logic              pulse
);
  assign key_hit = key_wr && (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= key_hit;
  end

  AST_WRONG_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata != KEY) |=> !pulse); // R9
endmodule

// File: rtl/irq_rst_regs.sv
module irq_rst_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = REG_ADDR_W,
  parameter int unsigned DATA_W  = REG_DATA_W,
  parameter int unsigned NUM_SRC = EVT_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_out,
  output logic               soft_rst_pulse
);
  localparam logic [ADDR_W-1:0] A_GATE   = ADDR_W'(OFS_GATE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_RESET  = ADDR_W'(OFS_RESET);
  localparam int unsigned       PAD_W    = DATA_W - NUM_SRC;

  function automatic logic line_level(input logic [NUM_SRC-1:0] pend, input logic gate);
    return gate && (|pend);
  endfunction

  // named write strobes
  logic wr_gate, wr_status, wr_enable, wr_reset;
  assign wr_gate   = bus_we && (bus_addr == A_GATE);
  assign wr_status = bus_we && (bus_addr == A_STATUS);
  assign wr_enable = bus_we && (bus_addr == A_ENABLE);
  assign wr_reset  = bus_we && (bus_addr == A_RESET);

  logic               gate_q;
  logic               key_hit;
  logic [NUM_SRC-1:0] status, enable, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (wr_gate) gate_q <= bus_wdata[GATE_BIT];
  end

  soft_reset_decoder #(.DATA_W(DATA_W), .KEY(DATA_W'(RESET_KEY))) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wr_reset),
    .wdata   (bus_wdata),
    .key_hit (key_hit),
    .pulse   (soft_rst_pulse)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_in),
    .clr_we    (wr_status),
    .clr_mask  (bus_wdata[NUM_SRC-1:0]),
    .ena_we    (wr_enable),
    .ena_wdata (bus_wdata[NUM_SRC-1:0]),
    .soft_clr  (key_hit),
    .status    (status),
    .enable    (enable),
    .pending   (pending)
  );

  assign irq_out = line_level(pending, gate_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GATE:   bus_rdata[GATE_BIT] = gate_q;
      A_STATUS: bus_rdata = {{PAD_W{1'b0}}, status};
      A_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable};
      default:  bus_rdata = '0;
    endcase
  end

  AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !irq_out); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & enable) != '0)); // R6

  AST_PULSE_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (status == '0 && enable == '0)); // R8

  AST_GATE_KEPT_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $stable(gate_q)); // R8
endmodule

// File: tb/test_irq_rst_regs.sv
module test_irq_rst_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_in = '0;
  logic        irq_out;
  logic        soft_rst_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_rst_regs i_irq_rst_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq_out(irq_out), .soft_rst_pulse(soft_rst_pulse)
  );

  // {we, addr, wdata, evt, read addr, exp read, exp irq, exp pulse}
  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  evt;
    logic [7:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_pulse;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,         8'h05, 8'h20, 32'h05,        1'b0, 1'b0}, // R2
    '{1'b1, 8'h28, 32'hFFFF_FF04, 8'h00, 8'h28, 32'h04,        1'b0, 1'b0}, // R5
    '{1'b1, 8'h1C, 32'hFFFF_FFFF, 8'h00, 8'h1C, 32'h8000_0000, 1'b1, 1'b0}, // R7 R6
    '{1'b1, 8'h20, 32'h0000_0004, 8'h00, 8'h20, 32'h01,        1'b0, 1'b0}, // R3
    '{1'b1, 8'h20, 32'h0000_0000, 8'h10, 8'h20, 32'h11,        1'b0, 1'b0}, // R3
    '{1'b1, 8'h20, 32'h0000_0010, 8'h10, 8'h20, 32'h11,        1'b0, 1'b0}, // R4
    '{1'b1, 8'h28, 32'h0000_0010, 8'h00, 8'h20, 32'h11,        1'b1, 1'b0}, // R6
    '{1'b1, 8'h1C, 32'h7FFF_FFFF, 8'h00, 8'h1C, 32'h0,         1'b0, 1'b0}, // R7 R6
    '{1'b1, 8'h40, 32'h0000_001A, 8'h00, 8'h28, 32'h10,        1'b0, 1'b0}, // R9
    '{1'b1, 8'h40, 32'h0000_000B, 8'h00, 8'h20, 32'h11,        1'b0, 1'b0}, // R9
    '{1'b0, 8'h00, 32'h0,         8'h00, 8'h40, 32'h0,         1'b0, 1'b0}, // R10
    '{1'b0, 8'h00, 32'h0,         8'h00, 8'h44, 32'h0,         1'b0, 1'b0}  // R10
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, release just after rising edge, then read raddr
  task automatic step(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                      input logic [7:0] ev, input logic [7:0] raddr);
    @(negedge clk);
    bus_we = we; bus_addr = addr; bus_wdata = wd; evt_in = ev;
    @(posedge clk);
    #1;
    bus_we = 1'b0; evt_in = '0; bus_addr = raddr;
    #1;
  endtask

  task automatic peek(input logic [7:0] raddr);
    bus_addr = raddr;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    peek(8'h20); check("R1", "status", bus_rdata, 32'h0);
    peek(8'h28); check("R1", "enable", bus_rdata, 32'h0);
    peek(8'h1C); check("R1", "gate",   bus_rdata, 32'h0);
    check("R1", "irq",   {31'b0, irq_out}, 32'h0);
    check("R1", "pulse", {31'b0, soft_rst_pulse}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].evt, VECS[i].raddr);
      check($sformatf("vec%0d", i), "rdata", bus_rdata, VECS[i].exp_rd);
      check($sformatf("vec%0d R6", i), "irq", {31'b0, irq_out}, {31'b0, VECS[i].exp_irq});
      check($sformatf("vec%0d R9", i), "pulse", {31'b0, soft_rst_pulse}, {31'b0, VECS[i].exp_pulse});
    end

    // R2: all eight sources at once, upper bits zero
    step(1'b0, 8'h00, 32'h0, 8'hFF, 8'h20);
    check("R2", "all sources", bus_rdata, 32'h0000_00FF);
    check("R6", "irq with bit4 enabled, gate off", {31'b0, irq_out}, 32'h0);

    // gate on again, then key write with a coincident event (R8)
    step(1'b1, 8'h1C, 32'h8000_0000, 8'h00, 8'h1C);
    check("R7", "gate on", bus_rdata, 32'h8000_0000);
    check("R6", "irq on", {31'b0, irq_out}, 32'h1);
    step(1'b1, 8'h40, 32'h0000_000A, 8'h80, 8'h20);
    check("R8", "pulse high", {31'b0, soft_rst_pulse}, 32'h1);
    check("R8", "status wiped, event dropped", bus_rdata, 32'h0);
    peek(8'h28); check("R8", "enable wiped", bus_rdata, 32'h0);
    peek(8'h1C); check("R8", "gate kept", bus_rdata, 32'h8000_0000);
    check("R8", "irq low", {31'b0, irq_out}, 32'h0);
    step(1'b0, 8'h00, 32'h0, 8'h80, 8'h20);
    check("R8", "pulse one cycle", {31'b0, soft_rst_pulse}, 32'h0);
    check("R2", "bit7 after reset pulse", bus_rdata, 32'h80);
    check("R6", "no enable no irq", {31'b0, irq_out}, 32'h0);
    step(1'b1, 8'h28, 32'h80, 8'h00, 8'h28);
    check("R5", "enable bit7", bus_rdata, 32'h80);
    check("R6", "irq bit7", {31'b0, irq_out}, 32'h1);
    step(1'b1, 8'h20, 32'hFFFF_FFFF, 8'h00, 8'h20);
    check("R3", "clear all", bus_rdata, 32'h0);
    check("R6", "irq drops after clear", {31'b0, irq_out}, 32'h0);

    finish_run();
  end
endmodule